// File: doc/BRIEF.md
# MIPS Subset Instruction Decoder

This block is the control unit of a single-cycle core that runs a small subset of 32-bit MIPS. It reads the 6-bit primary opcode and the 6-bit function field of the instruction being executed. From them it produces the one-bit steering controls for the datapath and a 4-bit code that tells the ALU which operation to perform. It is purely combinational: the controls settle within the same cycle in which the instruction is fetched, and the register file, data memory and PC logic act on them at the next clock edge.

Decoding runs on two paths. The first path looks only at the opcode and sets the one-bit controls for each instruction class. The second path looks at the opcode and, for register-format words, at the function field. It picks the ALU operation, marks shifts that take their amount from the shamt field, and tells register jumps and unknown function codes apart. A small merge stage joins the two results. Encodings outside the subset decode to controls that change neither the register file nor memory, so the PC simply advances by four.

Top module: `mips_subset_decoder`

## Requirements
- R1: For every nonzero opcode, all outputs are the same for all 64 function-field values.
- R2: ALU codes are ADD=0, SUB=1, AND=2, OR=3, SLT=4, SLTU=5, SLL=6, SRL=7, SRA=8, PASSB=9. The opcodes are addi 0x08, addiu 0x09, slti 0x0A, sltiu 0x0B, andi 0x0C, ori 0x0D, lui 0x0F, lw 0x23, sw 0x2B, beq 0x04, bne 0x05, j 0x02, jal 0x03.
- R3: jal (opcode 0x03) asserts reg_we, link and jump, selects rt/link as destination (dst_rd=0), and uses ALU code ADD. The datapath writes PC+4 to register 31 whenever link is high.
- R4: Opcode 0x00 words with function add 0x20, addu 0x21, and 0x24, or 0x25, slt 0x2A or sltu 0x2B assert reg_we and dst_rd, and take ALU B from a register (alu_b_imm=0). The ALU code is ADD, ADD, AND, OR, SLT and SLTU in that order.
- R5: The all-zero word decodes as a left shift by shamt (reg_we=1, dst_rd=1, shamt_sel=1, ALU SLL). Every control for memory, branches and jumps is low, so it writes only register 0.
- R6: jr (opcode 0x00, function 0x08) asserts jump_reg and dst_rd, and drives reg_we, mem_we and every other control low, with ALU code ADD.
- R7: lw asserts reg_we, mem_to_reg and alu_b_imm with dst_rd=0 and mem_we=0. sw asserts mem_we and alu_b_imm with reg_we=0. Both use ALU code ADD.
- R8: The immediate arithmetic and logic opcodes assert reg_we and alu_b_imm with dst_rd=0. andi and ori also assert imm_zext. lui asserts imm_upper and uses ALU code PASSB.
- R9: beq asserts br_eq and bne asserts br_ne. Both use ALU code SUB, take ALU B from a register, and write nothing.
- R10: sll (0x00), srl (0x02) and sra (0x03) under opcode 0x00 assert shamt_sel, reg_we and dst_rd, with ALU codes SLL, SRL and SRA.
- R11: An opcode outside R2 with a nonzero value drives every one-bit control low and ALU code ADD. An unknown function code under opcode 0x00 drives every control low except dst_rd, which stays 1, with ALU code ADD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode, instruction bits 31:26 |
| funct | input | 6 | Function field, instruction bits 5:0 |
| reg_we | output | 1 | Register file write enable |
| dst_rd | output | 1 | 1: write to rd, 0: write to rt (link overrides to 31) |
| alu_b_imm | output | 1 | ALU B operand is the extended immediate |
| mem_we | output | 1 | Data memory write enable |
| mem_to_reg | output | 1 | Register write data comes from memory |
| br_eq | output | 1 | Branch if the operands are equal |
| br_ne | output | 1 | Branch if the operands differ |
| jump | output | 1 | Jump to the 26-bit target |
| jump_reg | output | 1 | Jump to the address held in rs |
| link | output | 1 | Write PC+4 to register 31 |
| imm_zext | output | 1 | Zero-extend the immediate instead of sign-extending it |
| imm_upper | output | 1 | Place the immediate in the upper half-word |
| shamt_sel | output | 1 | Shift amount comes from the shamt field |
| alu_op | output | 4 | ALU operation code |

## Verification
The hardest case to reach is the claim that the opcode alone fixes the controls. A handful of chosen words would never show a stray function bit leaking into a non-register decode. The bench therefore holds each known nonzero opcode and sweeps all 64 function values, comparing every result with the one seen at function zero. In the same way, it walks the whole opcode space and the whole function space under opcode zero, so that every unlisted encoding is shown to write nothing.

// File: rtl/mips_dec_pkg.sv
package mips_dec_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int ALU_W = 4;

  localparam logic [OPC_W-1:0] OP_REG   = 6'h00;
  localparam logic [OPC_W-1:0] OP_J     = 6'h02;
  localparam logic [OPC_W-1:0] OP_JAL   = 6'h03;
  localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OP_BNE   = 6'h05;
  localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OPC_W-1:0] OP_ADDIU = 6'h09;
  localparam logic [OPC_W-1:0] OP_SLTI  = 6'h0A;
  localparam logic [OPC_W-1:0] OP_SLTIU = 6'h0B;
  localparam logic [OPC_W-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OPC_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OPC_W-1:0] OP_LUI   = 6'h0F;
  localparam logic [OPC_W-1:0] OP_LW    = 6'h23;
  localparam logic [OPC_W-1:0] OP_SW    = 6'h2B;

  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_JR   = 6'h08;
  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FN_W-1:0] FN_SLTU = 6'h2B;

  typedef enum logic [ALU_W-1:0] {
    ALU_ADD   = 4'd0,
    ALU_SUB   = 4'd1,
    ALU_AND   = 4'd2,
    ALU_OR    = 4'd3,
    ALU_SLT   = 4'd4,
    ALU_SLTU  = 4'd5,
    ALU_SLL   = 4'd6,
    ALU_SRL   = 4'd7,
    ALU_SRA   = 4'd8,
    ALU_PASSB = 4'd9
  } alu_op_e;

  // Controls fixed by the opcode alone (class level)
  typedef struct packed {
    logic is_reg;
    logic reg_we;
    logic b_imm;
    logic mem_we;
    logic mem_to_reg;
    logic br_eq;
    logic br_ne;
    logic jump;
    logic link;
    logic zext;
    logic upper;
  } cls_ctrl_t;

  localparam cls_ctrl_t CLS_IDLE = '0;
endpackage

// File: rtl/dec_class_ctrl.sv
module dec_class_ctrl
  import mips_dec_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic [OW-1:0] opcode,
  output cls_ctrl_t     cls
);
  always_comb begin
    cls = CLS_IDLE;
    unique case (opcode)
      OP_REG:   begin cls.is_reg = 1'b1; cls.reg_we = 1'b1; end
      OP_J:     cls.jump = 1'b1;
      OP_JAL:   begin cls.jump = 1'b1; cls.link = 1'b1; cls.reg_we = 1'b1; end
      OP_BEQ:   cls.br_eq = 1'b1;
      OP_BNE:   cls.br_ne = 1'b1;
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU:
                begin cls.reg_we = 1'b1; cls.b_imm = 1'b1; end
      OP_ANDI, OP_ORI:
                begin cls.reg_we = 1'b1; cls.b_imm = 1'b1; cls.zext = 1'b1; end
      OP_LUI:   begin cls.reg_we = 1'b1; cls.b_imm = 1'b1; cls.upper = 1'b1; end
      OP_LW:    begin cls.reg_we = 1'b1; cls.b_imm = 1'b1; cls.mem_to_reg = 1'b1; end
      OP_SW:    begin cls.mem_we = 1'b1; cls.b_imm = 1'b1; end
      default:  cls = CLS_IDLE;
    endcase
  end

  // R9: a branch class never writes state
  always_comb begin
    if (!$isunknown(opcode)) begin
      assert_branch_no_write_R9: assert (!((cls.br_eq || cls.br_ne) && (cls.reg_we || cls.mem_we)));
    end
  end
endmodule

// File: rtl/dec_alu_sel.sv
module dec_alu_sel
  import mips_dec_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int FW = FN_W,
  parameter int AW = ALU_W
) (
  input  logic [OW-1:0] opcode,
  input  logic [FW-1:0] funct,
  output logic [AW-1:0] alu_op,
  output logic          shamt_sel,
  output logic          fn_jr,
  output logic          fn_known
);
  alu_op_e reg_op, imm_op;
  logic    reg_shift;

  // Function-field path, only meaningful under opcode zero
  always_comb begin
    reg_op    = ALU_ADD;
    reg_shift = 1'b0;
    fn_jr     = 1'b0;
    fn_known  = 1'b1;
    unique case (funct)
      FN_SLL:  begin reg_op = ALU_SLL; reg_shift = 1'b1; end
      FN_SRL:  begin reg_op = ALU_SRL; reg_shift = 1'b1; end
      FN_SRA:  begin reg_op = ALU_SRA; reg_shift = 1'b1; end
      FN_JR:   fn_jr = 1'b1;
      FN_ADD, FN_ADDU: reg_op = ALU_ADD;
      FN_AND:  reg_op = ALU_AND;
      FN_OR:   reg_op = ALU_OR;
      FN_SLT:  reg_op = ALU_SLT;
      FN_SLTU: reg_op = ALU_SLTU;
      default: fn_known = 1'b0;
    endcase
  end

  // Opcode path for every other format
  always_comb begin
    unique case (opcode)
      OP_BEQ, OP_BNE:   imm_op = ALU_SUB;
      OP_SLTI:          imm_op = ALU_SLT;
      OP_SLTIU:         imm_op = ALU_SLTU;
      OP_ANDI:          imm_op = ALU_AND;
      OP_ORI:           imm_op = ALU_OR;
      OP_LUI:           imm_op = ALU_PASSB;
      default:          imm_op = ALU_ADD;
    endcase
  end

  always_comb begin
    if (opcode == OP_REG) begin
      alu_op    = reg_op;
      shamt_sel = reg_shift;
    end else begin
      alu_op    = imm_op;
      shamt_sel = 1'b0;
    end
  end

  // R10: shamt source implies a shift operation
  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      assert_shamt_is_shift_R10: assert (!shamt_sel ||
        alu_op inside {ALU_SLL, ALU_SRL, ALU_SRA});
    end
  end
endmodule

// File: rtl/mips_subset_decoder.sv
module mips_subset_decoder
  import mips_dec_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int FW = FN_W,
  parameter int AW = ALU_W
) (
  input  logic [OW-1:0] opcode,
  input  logic [FW-1:0] funct,
  output logic          reg_we,
  output logic          dst_rd,
  output logic          alu_b_imm,
  output logic          mem_we,
  output logic          mem_to_reg,
  output logic          br_eq,
  output logic          br_ne,
  output logic          jump,
  output logic          jump_reg,
  output logic          link,
  output logic          imm_zext,
  output logic          imm_upper,
  output logic          shamt_sel,
  output logic [AW-1:0] alu_op
);
  cls_ctrl_t       cls;
  logic [AW-1:0]   sel_op;
  logic            sel_shamt, fn_jr, fn_known;

  dec_class_ctrl #(.OW(OW)) i_cls (
    .opcode (opcode),
    .cls    (cls)
  );

  dec_alu_sel #(.OW(OW), .FW(FW), .AW(AW)) i_alu (
    .opcode    (opcode),
    .funct     (funct),
    .alu_op    (sel_op),
    .shamt_sel (sel_shamt),
    .fn_jr     (fn_jr),
    .fn_known  (fn_known)
  );

  // Merge: the function field only refines the register class
  always_comb begin
    reg_we     = cls.is_reg ? (fn_known && !fn_jr) : cls.reg_we;
    jump_reg   = cls.is_reg && fn_jr;
    dst_rd     = cls.is_reg;
    alu_b_imm  = cls.b_imm;
    mem_we     = cls.mem_we;
    mem_to_reg = cls.mem_to_reg;
    br_eq      = cls.br_eq;
    br_ne      = cls.br_ne;
    jump       = cls.jump;
    link       = cls.link;
    imm_zext   = cls.zext;
    imm_upper  = cls.upper;
    shamt_sel  = cls.is_reg && sel_shamt;
    alu_op     = sel_op;
  end

  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      assert_link_writes_R3: assert (!link || (reg_we && jump && !dst_rd));
      assert_jr_no_write_R6: assert (!jump_reg || (!reg_we && !mem_we));
      assert_store_no_reg_R7: assert (!mem_we || !reg_we);
      assert_branch_sub_R9: assert (!(br_eq || br_ne) || alu_op == AW'(ALU_SUB));
      assert_one_flow_R11: assert ($onehot0({br_eq, br_ne, jump, jump_reg}));
    end
  end
endmodule

// File: tb/test_mips_subset_decoder.sv
module test_mips_subset_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [5:0] opcode, funct;
  logic reg_we, dst_rd, alu_b_imm, mem_we, mem_to_reg, br_eq, br_ne;
  logic jump, jump_reg, link, imm_zext, imm_upper, shamt_sel;
  logic [3:0] alu_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mips_subset_decoder i_mips_subset_decoder (
    .opcode(opcode), .funct(funct), .reg_we(reg_we), .dst_rd(dst_rd),
    .alu_b_imm(alu_b_imm), .mem_we(mem_we), .mem_to_reg(mem_to_reg),
    .br_eq(br_eq), .br_ne(br_ne), .jump(jump), .jump_reg(jump_reg),
    .link(link), .imm_zext(imm_zext), .imm_upper(imm_upper),
    .shamt_sel(shamt_sel), .alu_op(alu_op)
  );

  // Bit order: reg_we dst_rd b_imm mem_we mem_to_reg br_eq br_ne jump jump_reg link zext upper shamt
  function automatic logic [12:0] obs();
    return {reg_we, dst_rd, alu_b_imm, mem_we, mem_to_reg, br_eq, br_ne,
            jump, jump_reg, link, imm_zext, imm_upper, shamt_sel};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(negedge clk);
    opcode = op;
    funct  = fn;
    #1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [12:0] exp_c, input logic [3:0] exp_a);
    checks++;
    if (obs() !== exp_c || alu_op !== exp_a) begin
      errors++;
      $display("FAIL %s %s: ctrl=%b alu=%0d expected ctrl=%b alu=%0d",
               req, what, obs(), alu_op, exp_c, exp_a);
    end
  endtask

  task automatic t_nop_r5;
    apply(6'h00, 6'h00);
    chk("R5", "all-zero word", 13'b1100000000001, 4'd6);
  endtask

  task automatic t_reg_alu_r4;
    apply(6'h00, 6'h20); chk("R4", "add",  13'b1100000000000, 4'd0);
    apply(6'h00, 6'h21); chk("R4", "addu", 13'b1100000000000, 4'd0);
    apply(6'h00, 6'h24); chk("R4", "and",  13'b1100000000000, 4'd2);
    apply(6'h00, 6'h25); chk("R4", "or",   13'b1100000000000, 4'd3);
    apply(6'h00, 6'h2A); chk("R4", "slt",  13'b1100000000000, 4'd4);
    apply(6'h00, 6'h2B); chk("R4", "sltu", 13'b1100000000000, 4'd5);
  endtask

  task automatic t_shift_r10;
    apply(6'h00, 6'h02); chk("R10", "srl", 13'b1100000000001, 4'd7);
    apply(6'h00, 6'h03); chk("R10", "sra", 13'b1100000000001, 4'd8);
  endtask

  task automatic t_jr_r6;
    apply(6'h00, 6'h08); chk("R6", "jr", 13'b0100000010000, 4'd0);
  endtask

  task automatic t_imm_r8;
    apply(6'h08, 6'h00); chk("R8", "addi",  13'b1010000000000, 4'd0);
    apply(6'h09, 6'h00); chk("R8", "addiu", 13'b1010000000000, 4'd0);
    apply(6'h0A, 6'h00); chk("R8", "slti",  13'b1010000000000, 4'd4);
    apply(6'h0B, 6'h00); chk("R8", "sltiu", 13'b1010000000000, 4'd5);
    apply(6'h0C, 6'h00); chk("R8", "andi",  13'b1010000000100, 4'd2);
    apply(6'h0D, 6'h00); chk("R8", "ori",   13'b1010000000100, 4'd3);
    apply(6'h0F, 6'h00); chk("R8", "lui",   13'b1010000000010, 4'd9);
  endtask

  task automatic t_mem_r7;
    apply(6'h23, 6'h00); chk("R7", "lw", 13'b1010100000000, 4'd0);
    apply(6'h2B, 6'h00); chk("R7", "sw", 13'b0011000000000, 4'd0);
  endtask

  task automatic t_branch_r9;
    apply(6'h04, 6'h00); chk("R9", "beq", 13'b0000010000000, 4'd1);
    apply(6'h05, 6'h00); chk("R9", "bne", 13'b0000001000000, 4'd1);
  endtask

  task automatic t_jump_r3;
    apply(6'h02, 6'h00); chk("R2", "j",   13'b0000000100000, 4'd0);
    apply(6'h03, 6'h00); chk("R3", "jal", 13'b1000000101000, 4'd0);
  endtask

  function automatic bit op_known(input logic [5:0] op);
    return op inside {6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h08, 6'h09, 6'h0A,
                      6'h0B, 6'h0C, 6'h0D, 6'h0F, 6'h23, 6'h2B};
  endfunction

  function automatic bit fn_known(input logic [5:0] fn);
    return fn inside {6'h00, 6'h02, 6'h03, 6'h08, 6'h20, 6'h21, 6'h24,
                      6'h25, 6'h2A, 6'h2B};
  endfunction

  // R1: function field ignored for every nonzero opcode
  task automatic t_funct_blind_r1;
    for (int o = 1; o < 64; o++) begin
      logic [12:0] ref_c;
      logic [3:0]  ref_a;
      int bad = 0;
      apply(6'(o), 6'h00);
      ref_c = obs();
      ref_a = alu_op;
      for (int f = 1; f < 64; f++) begin
        apply(6'(o), 6'(f));
        if (obs() !== ref_c || alu_op !== ref_a) begin
          if (bad == 0)
            $display("FAIL R1 op=%h fn=%h: ctrl=%b alu=%0d expected ctrl=%b alu=%0d",
                     o, f, obs(), alu_op, ref_c, ref_a);
          bad++;
        end
      end
      checks++;
      if (bad != 0) errors++;
    end
  endtask

  task automatic t_unknown_r11;
    for (int o = 1; o < 64; o++) begin
      if (!op_known(6'(o))) begin
        apply(6'(o), 6'h15);
        chk("R11", $sformatf("opcode %h", o), 13'b0000000000000, 4'd0);
      end
    end
    for (int f = 0; f < 64; f++) begin
      if (!fn_known(6'(f))) begin
        apply(6'h00, 6'(f));
        chk("R11", $sformatf("funct %h", f), 13'b0100000000000, 4'd0);
      end
    end
  endtask

  initial begin
    opcode = 6'h00;
    funct  = 6'h00;
    repeat (2) @(posedge clk);
    t_nop_r5();
    t_reg_alu_r4();
    t_shift_r10();
    t_jr_r6();
    t_imm_r8();
    t_mem_r7();
    t_branch_r9();
    t_jump_r3();
    t_funct_blind_r1();
    t_unknown_r11();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule